// File: doc/BRIEF.md
# Gated 16-bit Event Timer

This block is a 16-bit up-counter whose value lives in two byte-wide registers that software can read and load. Each count step comes from one of two sources: a one-cycle internal tick input, or the rising edges of an external clock input. The external clock input is first brought into the core clock domain. The selected events pass through a prescaler that divides by 1, 2, 4 or 8 before they reach the counter.

A gate input can qualify counting. When gating is turned on, the counter advances only while the synchronized gate level matches a programmable polarity. When the count wraps from all ones back to zero, a sticky overflow flag is set. The interrupt output carries this flag when the interrupt enable bit allows it.

Software reaches all state through a small register bus with a 2-bit address. It has a write strobe and a combinational read-data output.

Top module: `gated_tick_timer16`

## Requirements
- R1: After reset, both count bytes, the control register and the status register read 0x00, and `irq_o` is low.
- R2: With control bit 0 (run) set, control bit 1 (source) clear and prescale 0, the count goes up by one for each clock cycle in which `tick_en_i` is high. With run clear, the count does not change.
- R3: Control bits [3:2] hold the prescale code p. The counter advances once per 2^p qualified source events.
- R4: With control bit 1 set, the counter counts rising edges of `ext_clk_i` after a two-flop synchronizer, and `tick_en_i` has no effect.
- R5: With control bit 4 (gate mode) set, events count only while the synchronized `gate_i` equals control bit 5 (gate polarity: 1 means high enables, 0 means low enables). With bit 4 clear, `gate_i` has no effect.
- R6: Address 0 reads and writes count bits [7:0] and address 1 reads and writes count bits [15:8]. A byte write in the same cycle as an increment wins, so the written value is kept.
- R7: A write to either count byte restarts the prescaler, so a full 2^p further events are needed for the next increment.
- R8: Status bit 0 (address 3) is set by an increment that takes the count from 0xFFFF to 0x0000, and by nothing else.
- R9: The overflow flag stays set until a write to address 3 with data bit 0 equal to 1. A write with bit 0 equal to 0 leaves it set.
- R10: `irq_o` is high exactly when the overflow flag is set and control bit 6 (interrupt enable) is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en_i | input | 1 | Internal count event, one per high cycle |
| ext_clk_i | input | 1 | Asynchronous external clock |
| gate_i | input | 1 | Asynchronous gate level |
| bus_addr_i | input | 2 | Register select: 0 count low, 1 count high, 2 control, 3 status |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the selected register |
| irq_o | output | 1 | Overflow interrupt |

## Verification
A prescaler phase that is wrong, or that survives a count write, shows up as an early or late step in the readable count. This appears within at most eight source events. A wrong synchronizer depth or a faulty edge detector shows as a count that differs from the number of external edges, or as counting on the internal tick, after one burst of edges. A wrong gate polarity or a flag that fails to stick appears at once as a frozen or a running count, or as a status read and `irq_o` level that do not match the wrap the bench has just forced.

// File: rtl/gtmr_pkg.sv
// Package: shared register selects and the control word layout for the
// gated 16-bit event timer. Assumes an 8-bit register bus with 2 address bits.
package gtmr_pkg;

    localparam int BUS_AW = 2;

    typedef enum logic [BUS_AW-1:0] {
        SEL_CNT_LO = 2'd0,
        SEL_CNT_HI = 2'd1,
        SEL_CTRL   = 2'd2,
        SEL_STAT   = 2'd3
    } reg_sel_e;

    // Control word, bit 6 down to bit 0.
    typedef struct packed {
        logic       irq_en;     // bit 6
        logic       gate_pol;   // bit 5
        logic       gate_mode;  // bit 4
        logic [1:0] psel;       // bits 3:2
        logic       src_ext;    // bit 1
        logic       run;        // bit 0
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/bit_sync.sv
// Module: bit_sync
// Brings one asynchronous level into the clk domain through STAGES flops.
// Assumes STAGES >= 2 and that the input is held stable longer than a cycle.
module bit_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] chain_q;

    // Shift the raw level through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_i};
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/event_select.sv
// Module: event_select
// Chooses the count event: the internal tick or a rising edge of the
// synchronized external clock. Then it applies run and gate qualification.
// Assumes ext_lvl_i and gate_lvl_i are already synchronous to clk.
module event_select (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en_i,
    input  logic ext_lvl_i,
    input  logic gate_lvl_i,
    input  logic run_i,
    input  logic src_ext_i,
    input  logic gate_mode_i,
    input  logic gate_pol_i,
    output logic event_o
);

    logic ext_prev_q;
    logic ext_rise;
    logic gate_ok;
    logic raw_evt;

    // Remember the last synchronized external level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ext_prev_q <= 1'b0;
        else        ext_prev_q <= ext_lvl_i;
    end

    // Form the qualified event from the source, run and gate controls.
    always_comb begin
        ext_rise = ext_lvl_i & ~ext_prev_q;
        raw_evt  = src_ext_i ? ext_rise : tick_en_i;
        gate_ok  = ~gate_mode_i | (gate_lvl_i == gate_pol_i);
        event_o  = run_i & gate_ok & raw_evt;
    end

endmodule

// File: rtl/event_prescaler.sv
// Module: event_prescaler
// Passes one of every 2^psel events. A clear input restarts the phase.
// Assumes clear_i and event_i may coincide; the clear wins.
module event_prescaler #(
    parameter int PS_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear_i,
    input  logic            event_i,
    input  logic [PS_W-1:0] psel_i,
    output logic            step_o
);

    localparam int PC_W = (1 << PS_W) - 1;

    logic [PC_W-1:0] phase_q;
    logic [PC_W-1:0] limit;
    logic            at_limit;

    // Terminal phase for the selected ratio.
    always_comb begin
        limit    = PC_W'((1 << psel_i) - 1);
        at_limit = (phase_q >= limit);
        step_o   = event_i & at_limit & ~clear_i;
    end

    // Advance or restart the phase counter.
    always_ff @(posedge clk) begin
        if (!rst_n)             phase_q <= '0;
        else if (clear_i)       phase_q <= '0;
        else if (event_i)       phase_q <= at_limit ? '0 : phase_q + 1'b1;
    end

endmodule

// File: rtl/byte_counter.sv
// Module: byte_counter
// Up-counter made of NBYTES byte lanes. Each lane can be loaded on its own,
// and a load has priority over an increment. Flags the all-ones to zero wrap.
module byte_counter #(
    parameter int BYTE_W = 8,
    parameter int NBYTES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NBYTES-1:0]        load_i,
    input  logic [BYTE_W-1:0]        ldata_i,
    input  logic                     inc_i,
    output logic [NBYTES*BYTE_W-1:0] count_o,
    output logic                     wrap_o
);

    localparam int CW = NBYTES * BYTE_W;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_inc;
    logic          any_load;

    // Precompute the incremented value and the wrap condition.
    always_comb begin
        cnt_inc  = cnt_q + 1'b1;
        any_load = |load_i;
        wrap_o   = inc_i & ~any_load & (&cnt_q);
    end

    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        // Each lane takes a load, else the incremented slice.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cnt_q[b*BYTE_W +: BYTE_W] <= '0;
            else if (load_i[b])
                cnt_q[b*BYTE_W +: BYTE_W] <= ldata_i;
            else if (inc_i && !any_load)
                cnt_q[b*BYTE_W +: BYTE_W] <= cnt_inc[b*BYTE_W +: BYTE_W];
        end
    end

    assign count_o = cnt_q;

endmodule

// File: rtl/gated_tick_timer16.sv
// Module: gated_tick_timer16
// Top: 16-bit gated event timer with register bus, prescaler, sticky
// overflow flag and interrupt output. Assumes one register access per cycle
// and reads that have no side effects.
module gated_tick_timer16
    import gtmr_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int PS_W      = 2,
    parameter int SYNC_DEPTH = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_en_i,
    input  logic                ext_clk_i,
    input  logic                gate_i,
    input  logic [BUS_AW-1:0]   bus_addr_i,
    input  logic                bus_wr_i,
    input  logic [BYTE_W-1:0]   bus_wdata_i,
    output logic [BYTE_W-1:0]   bus_rdata_o,
    output logic                irq_o
);

    localparam int NBYTES = 2;
    localparam int CW     = NBYTES * BYTE_W;

    ctrl_t           ctrl_q;
    logic            ovf_flag_q;
    logic [CW-1:0]   count_q;
    logic [NBYTES-1:0] cnt_load;
    logic            cnt_wr;
    logic            ctrl_wr;
    logic            clr_req;
    logic            ext_lvl;
    logic            gate_lvl;
    logic            qual_evt;
    logic            step;
    logic            wrap;
    reg_sel_e        sel;

    // Decode bus writes into per-register strobes.
    always_comb begin
        sel         = reg_sel_e'(bus_addr_i);
        cnt_load[0] = bus_wr_i && (sel == SEL_CNT_LO);
        cnt_load[1] = bus_wr_i && (sel == SEL_CNT_HI);
        cnt_wr      = |cnt_load;
        ctrl_wr     = bus_wr_i && (sel == SEL_CTRL);
        clr_req     = bus_wr_i && (sel == SEL_STAT) && bus_wdata_i[0];
    end

    bit_sync #(.STAGES(SYNC_DEPTH)) i_ext_sync (
        .clk(clk), .rst_n(rst_n), .async_i(ext_clk_i), .sync_o(ext_lvl)
    );

    bit_sync #(.STAGES(SYNC_DEPTH)) i_gate_sync (
        .clk(clk), .rst_n(rst_n), .async_i(gate_i), .sync_o(gate_lvl)
    );

    event_select i_evt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en_i  (tick_en_i),
        .ext_lvl_i  (ext_lvl),
        .gate_lvl_i (gate_lvl),
        .run_i      (ctrl_q.run),
        .src_ext_i  (ctrl_q.src_ext),
        .gate_mode_i(ctrl_q.gate_mode),
        .gate_pol_i (ctrl_q.gate_pol),
        .event_o    (qual_evt)
    );

    event_prescaler #(.PS_W(PS_W)) i_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear_i(cnt_wr),
        .event_i(qual_evt),
        .psel_i (ctrl_q.psel),
        .step_o (step)
    );

    byte_counter #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) i_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (cnt_load),
        .ldata_i(bus_wdata_i),
        .inc_i  (step),
        .count_o(count_q),
        .wrap_o (wrap)
    );

    // Control register: loaded from the low bits of the write data.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_wr) ctrl_q <= ctrl_t'(bus_wdata_i[CTRL_W-1:0]);
    end

    // Sticky overflow flag: a wrap sets it, and a set wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       ovf_flag_q <= 1'b0;
        else if (wrap)    ovf_flag_q <= 1'b1;
        else if (clr_req) ovf_flag_q <= 1'b0;
    end

    // Read-data multiplexer.
    always_comb begin
        bus_rdata_o = '0;
        case (sel)
            SEL_CNT_LO: bus_rdata_o = count_q[BYTE_W-1:0];
            SEL_CNT_HI: bus_rdata_o = count_q[CW-1:BYTE_W];
            SEL_CTRL:   bus_rdata_o[CTRL_W-1:0] = ctrl_q;
            SEL_STAT:   bus_rdata_o[0] = ovf_flag_q;
            default:    bus_rdata_o = '0;
        endcase
    end

    assign irq_o = ovf_flag_q & ctrl_q.irq_en;

endmodule

// File: rtl/gated_tick_timer16_chk.sv
// Module: gated_tick_timer16_chk
// Temporal checks on the timer, attached by bind. Observes only.
module gated_tick_timer16_chk
    import gtmr_pkg::*;
#(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [CW-1:0] count,
    input logic          flag,
    input logic          irq,
    input ctrl_t         ctrl,
    input logic          gate_lvl,
    input logic          cnt_wr,
    input logic          clr_req
);

    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cnt_wr) && count != $past(count)) |-> (count == $past(count) + 1'b1)); // R2
    AST_HALT_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!ctrl.run && !cnt_wr) |-> $stable(count)); // R2
    AST_GATE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctrl.gate_mode && (gate_lvl != ctrl.gate_pol) && !cnt_wr) |-> $stable(count)); // R5
    AST_FLAG_ONLY_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> ($past(count) == {CW{1'b1}} && count == '0)); // R8
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(flag && !clr_req) |-> flag); // R9
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        !flag |-> !irq); // R10

endmodule

bind gated_tick_timer16 gated_tick_timer16_chk #(.CW(CW)) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .count   (count_q),
    .flag    (ovf_flag_q),
    .irq     (irq_o),
    .ctrl    (ctrl_q),
    .gate_lvl(gate_lvl),
    .cnt_wr  (cnt_wr),
    .clr_req (clr_req)
);

// File: tb/test_gated_tick_timer16.sv
`timescale 1ns/1ps
module test_gated_tick_timer16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       ext_clk = 1'b0;
    logic       gate = 1'b0;
    logic [1:0] addr = 2'd0;
    logic       wr = 1'b0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    gated_tick_timer16 i_gated_tick_timer16 (
        .clk(clk), .rst_n(rst_n), .tick_en_i(tick_en), .ext_clk_i(ext_clk),
        .gate_i(gate), .bus_addr_i(addr), .bus_wr_i(wr), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .irq_o(irq)
    );

    typedef struct packed {
        logic [1:0]  ps;
        logic [15:0] start;
        logic [15:0] ticks;
        logic [15:0] expc;
        logic        expf;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 16'h0000, 16'd5,  16'h0005, 1'b0},
        '{2'd1, 16'h0010, 16'd9,  16'h0014, 1'b0},
        '{2'd2, 16'h0100, 16'd17, 16'h0104, 1'b0},
        '{2'd3, 16'h1000, 16'd23, 16'h1002, 1'b0},
        '{2'd0, 16'hFFFD, 16'd3,  16'h0000, 1'b1},
        '{2'd3, 16'hFFFF, 16'd8,  16'h0000, 1'b1},
        '{2'd2, 16'h00FF, 16'd4,  16'h0100, 1'b0}
    };

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        addr = a;
        #0.5;
        d = rdata;
    endtask

    task automatic read_count(output logic [15:0] c);
        logic [7:0] lo, hi;
        bus_read(2'd0, lo);
        bus_read(2'd1, hi);
        c = {hi, lo};
    endtask

    task automatic read_flag(output logic [15:0] f);
        logic [7:0] s;
        bus_read(2'd3, s);
        f = {8'd0, s};
    endtask

    task automatic pulse_ticks(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic load_count(input logic [15:0] v);
        bus_write(2'd0, v[7:0]);
        bus_write(2'd1, v[15:8]);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #400000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] c, f;
        logic [7:0]  r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        read_count(c); check("R1 count", c, 16'h0000);
        bus_read(2'd2, r); check("R1 ctrl", {8'd0, r}, 16'h0000);
        read_flag(f); check("R1 status", f, 16'h0000);
        check("R1 irq", {15'd0, irq}, 16'h0000);

        // R2 R3 R8: vector table with the internal tick
        for (int i = 0; i < NV; i++) begin
            bus_write(2'd2, {4'd0, VECS[i].ps, 2'b00});
            load_count(VECS[i].start);
            bus_write(2'd3, 8'h01);
            bus_write(2'd2, {4'd0, VECS[i].ps, 2'b01});
            pulse_ticks(int'(VECS[i].ticks));
            read_count(c); check($sformatf("R3 vec%0d count", i), c, VECS[i].expc);
            read_flag(f);  check($sformatf("R8 vec%0d flag", i), f, {15'd0, VECS[i].expf});
        end
        bus_write(2'd3, 8'h01);

        // R2: run clear freezes the count
        bus_write(2'd2, 8'h00);
        load_count(16'h0123);
        pulse_ticks(5);
        read_count(c); check("R2 stopped", c, 16'h0123);

        // R6: byte readback and write priority over an increment
        bus_write(2'd2, 8'h01);
        load_count(16'hA55A);
        read_count(c); check("R6 readback", c, 16'hA55A);
        @(negedge clk);
        tick_en = 1'b1; addr = 2'd0; wdata = 8'h40; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0; tick_en = 1'b0;
        read_count(c); check("R6 write wins", c, 16'hA540);

        // R7: count write restarts the prescaler (divide by 8)
        bus_write(2'd2, 8'h0D);
        load_count(16'h0000);
        pulse_ticks(5);
        bus_write(2'd0, 8'h10);
        pulse_ticks(7);
        read_count(c); check("R7 no early step", c, 16'h0010);
        pulse_ticks(1);
        read_count(c); check("R7 step after 8", c, 16'h0011);

        // R4: external clock edges, internal tick held high and ignored
        bus_write(2'd2, 8'h03);
        load_count(16'h0000);
        tick_en = 1'b1;
        for (int k = 0; k < 10; k++) begin
            ext_clk = 1'b1; repeat (3) @(negedge clk);
            ext_clk = 1'b0; repeat (3) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        tick_en = 1'b0;
        read_count(c); check("R4 ext edges", c, 16'd10);

        // R5: gate mode with both polarities, then gate mode off
        bus_write(2'd2, 8'h31);
        gate = 1'b0; repeat (4) @(negedge clk);
        load_count(16'h0000);
        pulse_ticks(10);
        read_count(c); check("R5 gate low blocks", c, 16'd0);
        gate = 1'b1; repeat (4) @(negedge clk);
        pulse_ticks(10);
        read_count(c); check("R5 gate high counts", c, 16'd10);
        bus_write(2'd2, 8'h11);
        pulse_ticks(6);
        read_count(c); check("R5 inverted blocks", c, 16'd10);
        gate = 1'b0; repeat (4) @(negedge clk);
        pulse_ticks(6);
        read_count(c); check("R5 inverted counts", c, 16'd16);
        bus_write(2'd2, 8'h01);
        gate = 1'b1; repeat (4) @(negedge clk);
        pulse_ticks(2);
        read_count(c); check("R5 gate ignored", c, 16'd18);

        // R8 R9 R10: wrap, sticky flag, interrupt enable
        bus_write(2'd2, 8'h00);
        load_count(16'hFFFE);
        bus_write(2'd3, 8'h01);
        bus_write(2'd2, 8'h01);
        pulse_ticks(1);
        read_flag(f); check("R8 no flag at FFFF", f, 16'h0000);
        pulse_ticks(1);
        read_count(c); check("R8 wrapped", c, 16'h0000);
        read_flag(f); check("R8 flag set", f, 16'h0001);
        check("R10 irq masked", {15'd0, irq}, 16'h0000);
        bus_write(2'd2, 8'h41);
        check("R10 irq on", {15'd0, irq}, 16'h0001);
        bus_write(2'd3, 8'h00);
        read_flag(f); check("R9 zero write keeps", f, 16'h0001);
        bus_write(2'd3, 8'h01);
        read_flag(f); check("R9 cleared", f, 16'h0000);
        check("R10 irq off", {15'd0, irq}, 16'h0000);

        finish_run();
    end

endmodule